// File: doc/BRIEF.md
# Multicycle Accumulator CPU Core

This block is a small 16-bit accumulator processor that runs a program held in a private 4096-word memory. Each instruction word carries a 4-bit operation code in its top bits and a 12-bit word address below it. The core walks through a fixed fetch, decode and execute sequence, and every register-transfer step takes exactly one clock. The program counter and the memory address register can each be loaded straight from the internal datapath and can each be incremented where they sit. Because of this, fetch needs only two clocks and the jump-and-store-return instruction can write through an address register that has already been bumped.

A host holds the core in reset while the program image is placed in memory. It then releases reset and watches the outputs. One byte of input is always visible to the core. One byte of output is updated by the output instruction. A halted flag rises once the halt instruction has run, and the signed overflow flag of the last add or subtract is brought out as well.

The controller has seven named states. FETCH_ADDR copies PC into MAR. FETCH_READ latches the instruction word into IR and bumps PC. DECODE loads MAR from the address field. EXEC1, EXEC2 and EXEC3 carry out the execute steps. STOPPED is entered only by halt. The transitions are: FETCH_ADDR to FETCH_READ to DECODE to EXEC1. From any EXECn the controller goes to FETCH_ADDR once the opcode's last step is done, and otherwise to EXECn+1. EXEC1 goes to STOPPED for halt. STOPPED loops on itself until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, halted reads 0, overflow reads 0 and out_byte reads 0; PC, AC, IR, MAR and MBR are cleared and the run flag is set.
- R2: An instruction takes 3 + n clocks: two for fetch, one for decode, and n execute steps. Fetch first sets MAR to PC, then latches IR from memory and adds 1 to PC. Decode loads MAR with IR[11:0]. The value of n is 3 for opcodes 0x0, 0xB, 0xD and 0xE, 2 for 0x1 to 0x4, and 1 for all others.
- R3: Direct operand operations read M[MAR] into MBR and then act on it: 0x1 copies it into AC, 0x3 adds it to AC, 0x4 subtracts it from AC. Store (0x2) stages AC in MBR and then writes MBR to M[MAR].
- R4: The overflow flag is updated only by 0x3, 0x4 and 0xB. It becomes 1 on two's-complement signed overflow of the result and 0 otherwise.
- R5: Input (0x5) writes in_byte into AC[7:0] and leaves AC[15:8] untouched. Output (0x6) copies AC[7:0] to out_byte.
- R6: Halt (0x7) clears the run flag. From then on halted stays 1 and out_byte no longer changes until reset.
- R7: Skipcond (0x8) reads IR[11:10] and treats AC as signed. Code 00 tests AC<0, 01 tests AC==0 and 10 tests AC>0. When the chosen test is true, PC is incremented once more, which skips the next word.
- R8: Jump (0x9) sets PC to IR[11:0]. JumpI (0xC) sets PC to M[MAR][11:0].
- R9: JnS (0x0) takes three steps. First MBR[11:0] gets the incremented PC while MBR[15:12] is kept. Next MBR is written to M[MAR] and MAR is incremented. Last, PC gets MAR. Execution therefore resumes at the address after the stored word.
- R10: AddI (0xB), LoadI (0xD) and StoreI (0xE) first load MAR with M[MAR][11:0]. Then AddI and LoadI read the pointed-to word into MBR and add it to AC or copy it into AC. StoreI instead stages AC in MBR and then writes MBR to the pointed-to address.
- R11: Clear (0xA) sets AC to 0. Opcode 0xF and Skipcond with code 11 each take one execute step and leave AC, PC and the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | IO_W | Input register contents read by Input |
| out_byte | output | IO_W | Output register written by Output |
| halted | output | 1 | High once the run flag has been cleared |
| overflow | output | 1 | Signed overflow of the last add or subtract |

## Verification
The bench uses the default parameters: 16-bit data, 12-bit addresses and 8-bit I/O. With these, the full 4096-word address space and the real instruction encoding are available, so code can sit at low addresses, data and pointers can sit near 0x800 and 0x900, and subroutine slots can sit at 0x10. At this data width, the signed boundaries 0x7FFF and 0x8000 can be reached with single-operand programs, so the overflow flag can be driven both set and clear. An 8-bit output still allows the high byte of AC to be inspected indirectly, by subtracting and then branching on zero. The total clock count to halt shows the number of steps of every opcode.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        OP_JNS, OP_LOAD, OP_STORE, OP_ADD, OP_SUBT, OP_INPUT, OP_OUTPUT, OP_HALT,
        OP_SKIP, OP_JUMP, OP_CLEAR, OP_ADDI, OP_JUMPI, OP_LOADI, OP_STOREI, OP_NOP
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR, ST_FETCH_READ, ST_DECODE,
        ST_EXEC1, ST_EXEC2, ST_EXEC3, ST_STOPPED
    } state_e;

    typedef enum logic [2:0] {MAR_HOLD, MAR_FROM_PC, MAR_FROM_IR, MAR_FROM_MEM, MAR_INC} mar_sel_e;
    typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_FROM_IR, PC_FROM_MEM, PC_FROM_MAR} pc_sel_e;
    typedef enum logic [1:0] {MBR_HOLD, MBR_FROM_MEM, MBR_FROM_AC, MBR_FROM_PC} mbr_sel_e;
    typedef enum logic [2:0] {AC_HOLD, AC_FROM_MBR, AC_SUM, AC_DIFF, AC_ZERO, AC_FROM_IN} ac_sel_e;

    typedef struct packed {
        mar_sel_e mar_sel;
        pc_sel_e  pc_sel;
        mbr_sel_e mbr_sel;
        ac_sel_e  ac_sel;
        logic     mem_we;
        logic     ir_ld;
        logic     out_ld;
        logic     ovf_ld;
        logic     run_clr;
    } ctrl_t;

    // Number of execute steps for each operation.
    function automatic logic [1:0] exec_steps(input op_e op);
        unique case (op)
            OP_JNS, OP_ADDI, OP_LOADI, OP_STOREI: return 2'd3;
            OP_LOAD, OP_STORE, OP_ADD, OP_SUBT:   return 2'd2;
            default:                              return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words_q[addr] <= wdata;
    end

    // Read is combinational so a read and its use share one step.
    assign rdata = words_q[addr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] diff,
    output logic              sum_ovf,
    output logic              diff_ovf,
    output logic              acc_neg,
    output logic              acc_zero
);
    localparam int MSB = DATA_W - 1;

    assign sum      = acc + opnd;
    assign diff     = acc - opnd;
    assign sum_ovf  = (acc[MSB] == opnd[MSB]) && (sum[MSB] != acc[MSB]);
    assign diff_ovf = (acc[MSB] != opnd[MSB]) && (diff[MSB] != acc[MSB]);
    assign acc_neg  = acc[MSB];
    assign acc_zero = (acc == '0);
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_e        op,
    input  logic [1:0] skip_sel,
    input  logic       acc_neg,
    input  logic       acc_zero,
    output state_e     state,
    output ctrl_t      ctl
);
    state_e     state_q;
    logic [1:0] steps;
    logic       skip_hit;

    assign steps = exec_steps(op);
    assign state = state_q;

    always_comb begin
        unique case (skip_sel)
            2'b00:   skip_hit = acc_neg;
            2'b01:   skip_hit = acc_zero;
            2'b10:   skip_hit = !acc_neg && !acc_zero;
            default: skip_hit = 1'b0;
        endcase
    end

    // State register with its transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            unique case (state_q)
                ST_FETCH_ADDR: state_q <= ST_FETCH_READ;
                ST_FETCH_READ: state_q <= ST_DECODE;
                ST_DECODE:     state_q <= ST_EXEC1;
                ST_EXEC1:      state_q <= (op == OP_HALT) ? ST_STOPPED :
                                          (steps == 2'd1) ? ST_FETCH_ADDR : ST_EXEC2;
                ST_EXEC2:      state_q <= (steps == 2'd2) ? ST_FETCH_ADDR : ST_EXEC3;
                ST_EXEC3:      state_q <= ST_FETCH_ADDR;
                ST_STOPPED:    state_q <= ST_STOPPED;
                default:       state_q <= ST_FETCH_ADDR;
            endcase
        end
    end

    // Control word for the current step.
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_FETCH_ADDR: ctl.mar_sel = MAR_FROM_PC;
            ST_FETCH_READ: begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_sel = PC_INC;
            end
            ST_DECODE:     ctl.mar_sel = MAR_FROM_IR;
            ST_EXEC1: begin
                case (op)
                    OP_JNS:                   ctl.mbr_sel = MBR_FROM_PC;
                    OP_LOAD, OP_ADD, OP_SUBT: ctl.mbr_sel = MBR_FROM_MEM;
                    OP_STORE:                 ctl.mbr_sel = MBR_FROM_AC;
                    OP_INPUT:                 ctl.ac_sel  = AC_FROM_IN;
                    OP_OUTPUT:                ctl.out_ld  = 1'b1;
                    OP_HALT:                  ctl.run_clr = 1'b1;
                    OP_SKIP:                  ctl.pc_sel  = skip_hit ? PC_INC : PC_HOLD;
                    OP_JUMP:                  ctl.pc_sel  = PC_FROM_IR;
                    OP_CLEAR:                 ctl.ac_sel  = AC_ZERO;
                    OP_ADDI, OP_LOADI, OP_STOREI: ctl.mar_sel = MAR_FROM_MEM;
                    OP_JUMPI:                 ctl.pc_sel  = PC_FROM_MEM;
                    default:                  ctl = '0;
                endcase
            end
            ST_EXEC2: begin
                case (op)
                    OP_JNS: begin
                        ctl.mem_we  = 1'b1;
                        ctl.mar_sel = MAR_INC;
                    end
                    OP_LOAD:  ctl.ac_sel = AC_FROM_MBR;
                    OP_STORE: ctl.mem_we = 1'b1;
                    OP_ADD: begin
                        ctl.ac_sel = AC_SUM;
                        ctl.ovf_ld = 1'b1;
                    end
                    OP_SUBT: begin
                        ctl.ac_sel = AC_DIFF;
                        ctl.ovf_ld = 1'b1;
                    end
                    OP_ADDI, OP_LOADI: ctl.mbr_sel = MBR_FROM_MEM;
                    OP_STOREI:         ctl.mbr_sel = MBR_FROM_AC;
                    default:           ctl = '0;
                endcase
            end
            ST_EXEC3: begin
                case (op)
                    OP_JNS: ctl.pc_sel = PC_FROM_MAR;
                    OP_ADDI: begin
                        ctl.ac_sel = AC_SUM;
                        ctl.ovf_ld = 1'b1;
                    end
                    OP_LOADI:  ctl.ac_sel = AC_FROM_MBR;
                    OP_STOREI: ctl.mem_we = 1'b1;
                    default:   ctl = '0;
                endcase
            end
            ST_STOPPED: ctl = '0;
            default:    ctl = '0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_W-1:0]   in_byte,
    output logic [IO_W-1:0]   out_byte,
    output logic              halted,
    output logic              overflow
);
    localparam int OPC_W    = 4;
    localparam int SKIP_LSB = ADDR_W - 2;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, mbr_q, ac_q;
    logic [IO_W-1:0]   out_q;
    logic              ovf_q, run_q;

    logic [DATA_W-1:0] mem_rd, sum, diff;
    logic              sum_ovf, diff_ovf, acc_neg, acc_zero;
    state_e            ctrl_state;
    ctrl_t             ctl;
    op_e               op;

    assign op = op_e'(ir_q[DATA_W-1 -: OPC_W]);

    acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(ctl.mem_we), .addr(mar_q), .wdata(mbr_q), .rdata(mem_rd)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .acc(ac_q), .opnd(mbr_q), .sum(sum), .diff(diff),
        .sum_ovf(sum_ovf), .diff_ovf(diff_ovf), .acc_neg(acc_neg), .acc_zero(acc_zero)
    );

    acc_cpu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .skip_sel(ir_q[SKIP_LSB +: 2]),
        .acc_neg(acc_neg), .acc_zero(acc_zero), .state(ctrl_state), .ctl(ctl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            mbr_q <= '0;
            ac_q  <= '0;
            out_q <= '0;
            ovf_q <= 1'b0;
            run_q <= 1'b1;
        end else begin
            unique case (ctl.mar_sel)
                MAR_FROM_PC:  mar_q <= pc_q;
                MAR_FROM_IR:  mar_q <= ir_q[ADDR_W-1:0];
                MAR_FROM_MEM: mar_q <= mem_rd[ADDR_W-1:0];
                MAR_INC:      mar_q <= mar_q + 1'b1;
                default:      mar_q <= mar_q;
            endcase
            unique case (ctl.pc_sel)
                PC_INC:      pc_q <= pc_q + 1'b1;
                PC_FROM_IR:  pc_q <= ir_q[ADDR_W-1:0];
                PC_FROM_MEM: pc_q <= mem_rd[ADDR_W-1:0];
                PC_FROM_MAR: pc_q <= mar_q;
                default:     pc_q <= pc_q;
            endcase
            unique case (ctl.mbr_sel)
                MBR_FROM_MEM: mbr_q <= mem_rd;
                MBR_FROM_AC:  mbr_q <= ac_q;
                MBR_FROM_PC:  mbr_q[ADDR_W-1:0] <= pc_q;
                default:      mbr_q <= mbr_q;
            endcase
            unique case (ctl.ac_sel)
                AC_FROM_MBR: ac_q <= mbr_q;
                AC_SUM:      ac_q <= sum;
                AC_DIFF:     ac_q <= diff;
                AC_ZERO:     ac_q <= '0;
                AC_FROM_IN:  ac_q[IO_W-1:0] <= in_byte;
                default:     ac_q <= ac_q;
            endcase
            if (ctl.ir_ld)   ir_q  <= mem_rd;
            if (ctl.out_ld)  out_q <= ac_q[IO_W-1:0];
            if (ctl.ovf_ld)  ovf_q <= (ctl.ac_sel == AC_DIFF) ? diff_ovf : sum_ovf;
            if (ctl.run_clr) run_q <= 1'b0;
        end
    end

    assign out_byte = out_q;
    assign halted   = !run_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int IO_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            state,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] mar,
    input logic [DATA_W-1:0] ir,
    input logic [DATA_W-1:0] ac,
    input logic [IO_W-1:0]   in_byte,
    input logic [IO_W-1:0]   out_byte,
    input logic              halted,
    input logic              overflow
);
    logic [3:0] opc;
    logic       ex1;
    assign opc = ir[DATA_W-1 -: 4];
    assign ex1 = (state == ST_EXEC1);

    AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH_ADDR |=> state == ST_FETCH_READ); // R2
    AST_FETCH_PC_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH_READ |=> pc == $past(pc) + 1'b1); // R2
    AST_DECODE_MAR: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DECODE |=> mar == $past(ir[ADDR_W-1:0])); // R2
    AST_INPUT_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ex1 && opc == OP_INPUT |=> ac[DATA_W-1:IO_W] == $past(ac[DATA_W-1:IO_W])
                                   && ac[IO_W-1:0] == $past(in_byte)); // R5
    AST_OUTPUT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ex1 && opc == OP_OUTPUT |=> out_byte == $past(ac[IO_W-1:0])); // R5
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(out_byte)); // R6
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ex1 && opc == OP_JUMP |=> pc == $past(ir[ADDR_W-1:0])); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ex1 && opc == OP_CLEAR |=> ac == '0); // R11
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ex1 && opc == OP_NOP |=> $stable(ac) && $stable(pc) && $stable(overflow)); // R11
endmodule

bind acc_cpu_core acc_cpu_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(ctrl_state), .pc(pc_q), .mar(mar_q), .ir(ir_q),
    .ac(ac_q), .in_byte(in_byte), .out_byte(out_byte), .halted(halted), .overflow(overflow)
);

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] out_byte;
    logic       halted, overflow;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] prog    [4096];
    logic [15:0] ref_mem [4096];

    always #2 clk = ~clk;

    acc_cpu_core u_acc_cpu_core (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte),
        .out_byte(out_byte), .halted(halted), .overflow(overflow)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 4096; i++) prog[i] = 16'h0000;
    endtask

    // Instruction-level model built from the requirements.
    task automatic model(input logic [7:0] inb, output logic [7:0] o,
                         output logic ov, output int cyc);
        logic [11:0] pc, a, p;
        logic [15:0] ac, mbr, ir, r;
        logic        done;
        pc = '0; ac = '0; mbr = '0; o = '0; ov = 1'b0; cyc = 0; done = 1'b0;
        for (int i = 0; i < 4096; i++) ref_mem[i] = prog[i];
        for (int n = 0; n < 5000 && !done; n++) begin
            ir = ref_mem[pc]; pc = pc + 1'b1; cyc += 3; a = ir[11:0];
            case (ir[15:12])
                4'h0: begin mbr[11:0] = pc; ref_mem[a] = mbr; pc = a + 1'b1; cyc += 3; end
                4'h1: begin mbr = ref_mem[a]; ac = mbr; cyc += 2; end
                4'h2: begin mbr = ac; ref_mem[a] = mbr; cyc += 2; end
                4'h3: begin mbr = ref_mem[a]; r = ac + mbr;
                            ov = (ac[15] == mbr[15]) && (r[15] != ac[15]); ac = r; cyc += 2; end
                4'h4: begin mbr = ref_mem[a]; r = ac - mbr;
                            ov = (ac[15] != mbr[15]) && (r[15] != ac[15]); ac = r; cyc += 2; end
                4'h5: begin ac[7:0] = inb; cyc += 1; end
                4'h6: begin o = ac[7:0]; cyc += 1; end
                4'h7: begin done = 1'b1; cyc += 1; end
                4'h8: begin
                    if ((ir[11:10] == 2'b00 && $signed(ac) < 0) ||
                        (ir[11:10] == 2'b01 && ac == 16'h0) ||
                        (ir[11:10] == 2'b10 && $signed(ac) > 0)) pc = pc + 1'b1;
                    cyc += 1;
                end
                4'h9: begin pc = a; cyc += 1; end
                4'hA: begin ac = '0; cyc += 1; end
                4'hB: begin p = ref_mem[a][11:0]; mbr = ref_mem[p]; r = ac + mbr;
                            ov = (ac[15] == mbr[15]) && (r[15] != ac[15]); ac = r; cyc += 3; end
                4'hC: begin pc = ref_mem[a][11:0]; cyc += 1; end
                4'hD: begin p = ref_mem[a][11:0]; mbr = ref_mem[p]; ac = mbr; cyc += 3; end
                4'hE: begin p = ref_mem[a][11:0]; mbr = ac; ref_mem[p] = mbr; cyc += 3; end
                default: cyc += 1;
            endcase
        end
    endtask

    task automatic run_case(input string req, input logic [7:0] inb);
        logic [7:0] eo, held;
        logic       eov;
        int         ecyc, cyc;
        model(inb, eo, eov, ecyc);
        @(negedge clk);
        rst_n = 1'b0;
        in_byte = inb;
        for (int i = 0; i < 4096; i++) u_acc_cpu_core.u_mem.words_q[i] = prog[i];
        repeat (2) @(negedge clk);
        check("R1", "halted in reset", int'(halted), 0);
        check("R1", "overflow in reset", int'(overflow), 0);
        check("R1", "out_byte in reset", int'(out_byte), 0);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 6000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        check("R2", "clocks to halt", cyc, ecyc);
        check(req, "out_byte", int'(out_byte), int'(eo));
        check("R4", "overflow", int'(overflow), int'(eov));
        held = out_byte;
        repeat (8) @(negedge clk);
        check("R6", "halted held", int'(halted), 1);
        check("R6", "out_byte frozen", int'(out_byte), int'(held));
    endtask

    task automatic gen_random();
        int n, k;
        logic [3:0] d;
        clear_prog();
        for (int i = 0; i < 16; i++) begin
            k = $urandom % 6;
            prog[12'h800 + i] = (k == 0) ? 16'h7FFF : (k == 1) ? 16'h8000 :
                                (k == 2) ? 16'h0000 : 16'($urandom);
        end
        for (int i = 0; i < 4; i++) prog[12'h900 + i] = 16'h0800 + 16'($urandom % 16);
        n = 8 + ($urandom % 12);
        for (int i = 0; i < n; i++) begin
            d = 4'($urandom);
            case ($urandom % 14)
                0: prog[i] = ins(4'h1, {8'h80, d});
                1: prog[i] = ins(4'h3, {8'h80, d});
                2: prog[i] = ins(4'h4, {8'h80, d});
                3: prog[i] = ins(4'h2, {8'h80, d});
                4: prog[i] = ins(4'hA, 12'h0);
                5: prog[i] = ins(4'h5, 12'h0);
                6: prog[i] = ins(4'h6, 12'h0);
                7: prog[i] = ins(4'h8, {2'($urandom), 10'h0});
                8: prog[i] = ins(4'hF, 12'h0);
                9: prog[i] = ins(4'hD, {10'h240, d[1:0]});
                10: prog[i] = ins(4'hB, {10'h240, d[1:0]});
                11: prog[i] = ins(4'hE, {10'h240, d[1:0]});
                12: prog[i] = ins(4'h3, {8'h80, d});
                default: prog[i] = ins(4'h8, 12'h400);
            endcase
        end
        prog[n] = ins(4'h6, 12'h0);
        prog[n+1] = ins(4'h7, 12'h0);
        prog[n+2] = ins(4'h7, 12'h0);
    endtask

    initial begin
        void'($urandom(32'd20240613));

        // R6: halt alone, four clocks
        clear_prog();
        prog[0] = ins(4'h7, 12'h0);
        run_case("R6", 8'h00);

        // R3: load, add, store, clear, reload, subtract
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'h3, 12'h021);
        prog[2] = ins(4'h2, 12'h022); prog[3] = ins(4'hA, 12'h0);
        prog[4] = ins(4'h1, 12'h022); prog[5] = ins(4'h4, 12'h021);
        prog[6] = ins(4'h6, 12'h0);   prog[7] = ins(4'h7, 12'h0);
        prog[12'h020] = 16'h0005; prog[12'h021] = 16'h0003;
        run_case("R3", 8'h00);

        // R4: positive overflow on add
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'h3, 12'h021);
        prog[2] = ins(4'h6, 12'h0);   prog[3] = ins(4'h7, 12'h0);
        prog[12'h020] = 16'h7FFF; prog[12'h021] = 16'h0001;
        run_case("R4", 8'h00);

        // R4: negative overflow on subtract
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'h4, 12'h021);
        prog[2] = ins(4'h6, 12'h0);   prog[3] = ins(4'h7, 12'h0);
        prog[12'h020] = 16'h8000; prog[12'h021] = 16'h0001;
        run_case("R4", 8'h00);

        // R4: flag survives clear, then a clean add drops it
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'h3, 12'h021);
        prog[2] = ins(4'hA, 12'h0);   prog[3] = ins(4'h3, 12'h021);
        prog[4] = ins(4'h6, 12'h0);   prog[5] = ins(4'h7, 12'h0);
        prog[12'h020] = 16'h7FFF; prog[12'h021] = 16'h0001;
        run_case("R4", 8'h00);

        // R5: input keeps AC[15:8], shown by subtract and zero test
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'h5, 12'h0);
        prog[2] = ins(4'h4, 12'h021); prog[3] = ins(4'h8, 12'h400);
        prog[4] = ins(4'h9, 12'h040); prog[5] = ins(4'h1, 12'h022);
        prog[6] = ins(4'h6, 12'h0);   prog[7] = ins(4'h7, 12'h0);
        prog[12'h040] = ins(4'h1, 12'h023); prog[12'h041] = ins(4'h6, 12'h0);
        prog[12'h042] = ins(4'h7, 12'h0);
        prog[12'h020] = 16'h12FF; prog[12'h021] = 16'h1234;
        prog[12'h022] = 16'h00A5; prog[12'h023] = 16'h005A;
        run_case("R5", 8'h34);

        // R7 and R11: every skip code against negative, zero, positive AC
        for (int sel = 0; sel < 4; sel++) begin
            for (int v = 0; v < 3; v++) begin
                clear_prog();
                prog[0] = ins(4'h1, 12'h020);
                prog[1] = ins(4'h8, {2'(sel), 10'h0});
                prog[2] = ins(4'h9, 12'h040);
                prog[3] = ins(4'h1, 12'h021); prog[4] = ins(4'h6, 12'h0);
                prog[5] = ins(4'h7, 12'h0);
                prog[12'h040] = ins(4'h1, 12'h022); prog[12'h041] = ins(4'h6, 12'h0);
                prog[12'h042] = ins(4'h7, 12'h0);
                prog[12'h020] = (v == 0) ? 16'hFFFD : (v == 1) ? 16'h0000 : 16'h0005;
                prog[12'h021] = 16'h00C3; prog[12'h022] = 16'h003C;
                run_case((sel == 3) ? "R11" : "R7", 8'h00);
            end
        end

        // R8: indirect jump then direct jump
        clear_prog();
        prog[0] = ins(4'hC, 12'h030); prog[12'h030] = 16'h0040;
        prog[12'h040] = ins(4'h9, 12'h050);
        prog[12'h050] = ins(4'h1, 12'h060); prog[12'h051] = ins(4'h6, 12'h0);
        prog[12'h052] = ins(4'h7, 12'h0);   prog[12'h060] = 16'h005A;
        run_case("R8", 8'h00);

        // R9: subroutine call and return through the stored address
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'h0, 12'h010);
        prog[2] = ins(4'h6, 12'h0);   prog[3] = ins(4'h7, 12'h0);
        prog[12'h011] = ins(4'h3, 12'h021); prog[12'h012] = ins(4'hC, 12'h010);
        prog[12'h020] = 16'h0040; prog[12'h021] = 16'h0002;
        run_case("R9", 8'h00);

        // R9: the stored return word holds the incremented PC
        clear_prog();
        prog[0] = ins(4'h9, 12'h005);
        prog[5] = ins(4'h0, 12'h010);
        prog[12'h011] = ins(4'h1, 12'h010); prog[12'h012] = ins(4'h6, 12'h0);
        prog[12'h013] = ins(4'h7, 12'h0);
        run_case("R9", 8'h00);

        // R10: indirect load, add and store
        clear_prog();
        prog[0] = ins(4'hD, 12'h030); prog[1] = ins(4'hB, 12'h031);
        prog[2] = ins(4'hE, 12'h032); prog[3] = ins(4'hA, 12'h0);
        prog[4] = ins(4'h1, 12'h072); prog[5] = ins(4'h6, 12'h0);
        prog[6] = ins(4'h7, 12'h0);
        prog[12'h030] = 16'h0070; prog[12'h031] = 16'h0071; prog[12'h032] = 16'h0072;
        prog[12'h070] = 16'h0042; prog[12'h071] = 16'h0011;
        run_case("R10", 8'h00);

        // R11: reserved opcode leaves AC alone; clear empties it
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'hF, 12'h0);
        prog[2] = ins(4'h6, 12'h0);   prog[3] = ins(4'h7, 12'h0);
        prog[12'h020] = 16'h0077;
        run_case("R11", 8'h00);
        clear_prog();
        prog[0] = ins(4'h1, 12'h020); prog[1] = ins(4'hA, 12'h0);
        prog[2] = ins(4'h6, 12'h0);   prog[3] = ins(4'h7, 12'h0);
        prog[12'h020] = 16'h0077;
        run_case("R11", 8'h00);

        // R3: random straight-line programs
        for (int t = 0; t < 30; t++) begin
            gen_random();
            run_case("R3", 8'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule